// File: doc/BRIEF.md
# Grouped GPIO Interrupt Summary Unit

This unit sits between a bank of per-pin interrupt detectors and a host processor. Each pin detector supplies a single "pending" level. The unit folds these levels into group bits, one for each run of four adjacent pins, and registers the result once per clock. Software reads the group bits through two word-wide status registers. The low register holds groups 0 to 31. The high register holds groups 32 and up, and any bit position above the last real group reads as zero.

From the group bits the unit drives a single level-sensitive host interrupt line. Once the line is raised it stays latched, whatever the pins do, until software writes the end-of-interrupt bit in the master register. The host does not need to acknowledge the line before it services the interrupt. The EOI write drops the line for two cycles. After that the line is raised again if any group is still pending, so a source that stayed active cannot be missed.

Top module: `gpio_irq_summary`

## Requirements
- R1: Group bit k is the OR of the pending inputs of pins 4k, 4k+1, 4k+2 and 4k+3. The bit is visible in the status registers one clock edge after the inputs change.
- R2: Address 0 returns group bits 0 to 31 in data bits 0 to 31. Address 1 returns group bit 32+j in data bit j. With 184 pins there are 46 groups, so data bits 14 to 31 of address 1 always read as zero.
- R3: When no pin is pending, both status registers read zero. After an EOI, the host line stays low.
- R4: When the line is not latched, host_irq rises on the clock edge after a group bit becomes set. That is two edges after a pin input rises.
- R5: Once host_irq is high, it stays high until an EOI write, even if every pin input returns to zero.
- R6: Writing address 2 with data bit 0 set is an EOI. host_irq is low after the write edge and after the following edge. On the edge after that, host_irq rises again if any group bit is set.
- R7: A write to address 2 with data bit 0 clear has no effect on host_irq. Address 2 and address 3 always read zero, so the EOI bit reads back as 0.
- R8: Writes to address 0 or address 1 are ignored. They change neither the read values nor host_irq.
- R9: During and right after reset, host_irq is low and both status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pend | input | NPINS (184) | Pending level from each pin detector |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (2) | Register address: 0 low status, 1 high status, 2 master |
| reg_wdata | input | DW (32) | Write data; bit 0 of the master register is the EOI bit |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| host_irq | output | 1 | Host interrupt line |

## Verification
Properties check the following on every cycle:
- host_irq only rises after a set group bit.
- The line stays latched until an EOI.
- An EOI holds the line low for two edges.
- The unused high status bits and the master register read zero.
- An idle input vector clears the summary.

The bench sweeps every pin on its own, and every input combination of the last group. These sweeps show that each pin maps to the right group bit and register. The bench's scenarios alone show the following:
- Re-arming after an EOI while a source is still active.
- A write with the EOI bit clear having no effect.
- Status writes being ignored.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NPINS    = 184,
  parameter int GRP_PINS = 4,
  parameter int DW       = 32,
  parameter int AW       = 2,
  parameter int EOI_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_pend,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             host_irq
);

  localparam int NGRP = (NPINS + GRP_PINS - 1) / GRP_PINS;
  localparam int PADW = NGRP * GRP_PINS;
  localparam int SUMW = 2 * DW;
  localparam logic [SUMW-1:0] SUM_MASK =
    (NGRP >= SUMW) ? {SUMW{1'b1}} : ((SUMW'(1) << NGRP) - SUMW'(1));
  localparam logic [DW-1:0] HI_MASK = SUM_MASK[SUMW-1:DW];
  localparam logic [AW-1:0] ADDR_LO  = AW'(0);
  localparam logic [AW-1:0] ADDR_HI  = AW'(1);
  localparam logic [AW-1:0] ADDR_MST = AW'(2);

  logic [PADW-1:0] pend_pad;
  logic [NGRP-1:0] grp_or;
  logic [NGRP-1:0] sum_q;
  logic [SUMW-1:0] sum_full;
  logic            eoi_req;
  logic            gap_q;
  logic            irq_q;
  logic            unused_wdata;

  assign pend_pad = PADW'(pin_pend);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_or[g] = |pend_pad[g*GRP_PINS +: GRP_PINS];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sum_q <= '0;
    else        sum_q <= grp_or;

  assign sum_full = SUMW'(sum_q);

  always_comb begin
    case (reg_addr)
      ADDR_LO: reg_rdata = sum_full[DW-1:0];
      ADDR_HI: reg_rdata = sum_full[SUMW-1:DW];
      default: reg_rdata = '0;
    endcase
  end

  assign eoi_req      = reg_wr && (reg_addr == ADDR_MST) && reg_wdata[EOI_BIT];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      gap_q <= eoi_req;
      if (eoi_req || gap_q) irq_q <= 1'b0;
      else if (|sum_q)      irq_q <= 1'b1;
    end
  end

  assign host_irq = irq_q;

  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pend == '0) |=> (sum_q == '0));

  a_r2_hi_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_HI) |-> ((reg_rdata & ~HI_MASK) == '0));

  a_r4_rise_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|sum_q));

  a_r5_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !eoi_req) |=> host_irq);

  a_r6_eoi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req |=> !host_irq ##1 !host_irq);

  a_r7_master_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_MST) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_gpio_irq_summary.sv
`timescale 1ns/1ps
module sim_gpio_irq_summary;
  localparam int NP = 184;
  localparam int NG = 46;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP-1:0]  pin_pend = '0;
  logic           reg_wr = 1'b0;
  logic [1:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           host_irq;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  gpio_irq_summary u0 (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .host_irq(host_irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = 2'd0;
  endtask

  function automatic logic [63:0] expect_sum(logic [NP-1:0] pv);
    logic [63:0] s = '0;
    for (int k = 0; k < NG; k++)
      if (pv[4*k +: 4] != 4'd0) s[k] = 1'b1;
    return s;
  endfunction

  task automatic check_regs(string req, logic [NP-1:0] pv);
    logic [31:0] d;
    logic [63:0] e;
    e = expect_sum(pv);
    rd(2'd0, d); chk(req, d, e[31:0]);
    rd(2'd1, d); chk(req, d, e[63:32]);
  endtask

  task automatic apply(logic [NP-1:0] pv);
    @(negedge clk);
    pin_pend = pv;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R9 irq in reset", 32'(host_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 irq after reset", 32'(host_irq), 32'd0);
    check_regs("R9 status after reset", '0);

    for (int p = 0; p < NP; p++) begin
      apply(NP'(1) << p);
      check_regs("R1 R2 single pin sweep", NP'(1) << p);
    end

    for (int v = 0; v < 16; v++) begin
      logic [NP-1:0] pv;
      pv = '0;
      pv[183:180] = 4'(v);
      pv[3:0] = 4'(15 - v);
      apply(pv);
      check_regs("R1 group combos", pv);
    end

    apply('1);
    rd(2'd1, d); chk("R2 all pins high reg", d, 32'h0000_3FFF);
    rd(2'd0, d); chk("R2 all pins low reg", d, 32'hFFFF_FFFF);

    apply('0);
    wr(2'd2, 32'h1);
    repeat (3) @(negedge clk);
    chk("R3 idle irq", 32'(host_irq), 32'd0);
    check_regs("R3 idle status", '0);

    @(negedge clk);
    pin_pend = NP'(1) << 7;
    @(negedge clk);
    chk("R4 not yet", 32'(host_irq), 32'd0);
    @(negedge clk);
    chk("R4 rise", 32'(host_irq), 32'd1);

    apply('0);
    repeat (4) @(negedge clk);
    chk("R5 held after pins clear", 32'(host_irq), 32'd1);
    apply(NP'(1) << 60);
    apply('0);
    chk("R5 held across toggles", 32'(host_irq), 32'd1);

    wr(2'd2, 32'hFFFF_FFFE);
    chk("R7 no-eoi write", 32'(host_irq), 32'd1);
    @(negedge clk);
    chk("R7 no-eoi write later", 32'(host_irq), 32'd1);
    rd(2'd2, d); chk("R7 master reads zero", d, 32'd0);
    rd(2'd3, d); chk("R7 addr3 reads zero", d, 32'd0);

    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    check_regs("R8 status writes ignored", '0);
    chk("R8 irq unchanged", 32'(host_irq), 32'd1);

    wr(2'd2, 32'h1);
    chk("R6 low after eoi", 32'(host_irq), 32'd0);
    @(negedge clk);
    chk("R6 gap", 32'(host_irq), 32'd0);
    repeat (3) @(negedge clk);
    chk("R6 stays low idle", 32'(host_irq), 32'd0);

    apply(NP'(1) << 100);
    @(negedge clk);
    chk("R4 rise pin 100", 32'(host_irq), 32'd1);
    check_regs("R1 pin 100", NP'(1) << 100);
    wr(2'd2, 32'h1);
    chk("R6 low after eoi busy", 32'(host_irq), 32'd0);
    @(negedge clk);
    chk("R6 gap busy", 32'(host_irq), 32'd0);
    @(negedge clk);
    chk("R6 rearm busy", 32'(host_irq), 32'd1);
    rd(2'd2, d); chk("R7 eoi reads zero", d, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule